// File: doc/BRIEF.md
# Programmable 16-bit CRC Engine

This block computes a 16-bit cyclic redundancy check one byte at a time, with the generator polynomial supplied at run time. Software sets it up through a small byte-wide register window. It writes the polynomial as two bytes and starts a fresh calculation by clearing the remainder. The clear loads either zero or all ones. Data bytes are then supplied one after another, and the result is read back as a low byte and a high byte.

The result can be read complemented, bit-reversed, or both. These options act only on the read path; the stored remainder never changes because of them.

Instead of software writes, a direct-memory-access channel can deliver the data bytes through a valid/ready handshake. A control bit selects this mode.

With the parameter `SERIAL` set to 1 (the default), each byte is folded in over `DW` cycles, one bit per cycle, and the engine reports busy while it works. With `SERIAL` set to 0, a byte is folded in within a single cycle.

Top module: `crc16_prog`

## Requirements
- R1: After reset the remainder, polynomial and control bits are 0, `busy` is low, and every register reads as 0.
- R2: Address 1 holds the polynomial low byte and address 2 the high byte; both are writable and read back as written.
- R3: A write to address 0 with bit 1 set clears the remainder. It loads 0xFFFF if bit 0 of that same write is 1, else 0x0000. Bit 1 always reads back as 0.
- R4: Each byte is folded in MSB-first, without reflection. The byte is XORed into remainder bits 15:8, followed by eight steps of shift left by one, XORing in the polynomial whenever the bit shifted out was 1.
- R5: With control bit 2 set, the result reads as the bitwise complement of the remainder.
- R6: With control bit 4 set, the result reads bit-reversed across 16 bits. The two options combine, and clearing them returns the unmodified remainder.
- R7: Address 4 reads the result low byte and address 5 the high byte. `reg_rdata` is registered and reflects the address presented one clock earlier.
- R8: With `SERIAL`=1, `busy` is high for exactly 8 cycles after a byte is accepted, and `reg_ready` is low for those cycles. Control bit 7 reads the busy state.
- R9: Register writes made while `reg_ready` is low are not accepted and change nothing.
- R10: Control bit 3 selects DMA mode. In DMA mode a byte is taken on `dma_data` when `dma_valid` and `dma_ready` are both high, and software writes to address 3 are ignored. Outside DMA mode `dma_ready` stays low.
- R11: When a clear and a DMA byte are accepted in the same cycle, the seed value is loaded first and that byte is then folded into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| reg_ready | output | 1 | Writes are accepted while high |
| dma_valid | input | 1 | DMA byte offered |
| dma_data | input | 8 | DMA byte |
| dma_ready | output | 1 | DMA byte accepted when high together with valid |
| busy | output | 1 | Byte fold in progress |

## Verification
The case that needs care is a remainder clear and a data byte landing on the same clock edge. This can only happen in DMA mode, because software cannot write two registers at once. The bench provokes it by raising `dma_valid` in the same cycle that it writes a control word holding both the clear and the seed bit. It then reads the result and compares it against a model that loads the seed first and folds the byte in afterwards. A design that drops the byte, or that applies the byte before the seed load, gives a different value.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  typedef enum logic [2:0] {
    A_CTRL    = 3'd0,
    A_POLY_LO = 3'd1,
    A_POLY_HI = 3'd2,
    A_DATA    = 3'd3,
    A_RES_LO  = 3'd4,
    A_RES_HI  = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic flip;
    logic dma;
    logic inv;
    logic seed;
  } ctrl_t;
endpackage

// File: rtl/crc16_regs.sv
module crc16_regs
  import crc16_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    addr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  output ctrl_t         ctrl,
  output logic [CW-1:0] poly,
  output logic          clr_fire,
  output logic          clr_seed,
  output logic          sw_byte_fire
);
  logic wr_ok;
  assign wr_ok        = wr && !busy;
  assign clr_fire     = wr_ok && (addr == A_CTRL) && wdata[1];
  assign clr_seed     = wdata[0];
  assign sw_byte_fire = wr_ok && (addr == A_DATA) && !ctrl.dma;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      poly <= '0;
    end else if (wr_ok) begin
      case (addr)
        A_CTRL: begin
          ctrl.seed <= wdata[0];
          ctrl.inv  <= wdata[2];
          ctrl.dma  <= wdata[3];
          ctrl.flip <= wdata[4];
        end
        A_POLY_LO: poly[DW-1:0]  <= wdata;
        A_POLY_HI: poly[CW-1:DW] <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/crc16_core.sv
module crc16_core #(
  parameter int DW = 8,
  parameter bit SERIAL = 1'b1,
  localparam int CW = 2 * DW,
  localparam int NW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] poly,
  input  logic          clr,
  input  logic          seed,
  input  logic          byte_fire,
  input  logic [DW-1:0] byte_in,
  output logic [CW-1:0] rem,
  output logic          busy
);
  function automatic logic [CW-1:0] shift1(input logic [CW-1:0] r, input logic [CW-1:0] p);
    return r[CW-1] ? ((r << 1) ^ p) : (r << 1);
  endfunction

  logic [CW-1:0] base, loaded;
  assign base   = clr ? (seed ? {CW{1'b1}} : {CW{1'b0}}) : rem;
  assign loaded = base ^ {byte_in, {DW{1'b0}}};

  generate
    if (SERIAL) begin : g_serial
      logic [NW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          rem  <= '0;
          cnt  <= '0;
          busy <= 1'b0;
        end else if (byte_fire) begin
          rem  <= loaded;
          cnt  <= NW'(DW);
          busy <= 1'b1;
        end else if (clr) begin
          rem  <= base;
          cnt  <= '0;
          busy <= 1'b0;
        end else if (busy) begin
          rem <= shift1(rem, poly);
          cnt <= cnt - 1'b1;
          if (cnt == NW'(1)) busy <= 1'b0;
        end
      end
    end else begin : g_parallel
      logic [CW-1:0] folded;
      always_comb begin
        folded = loaded;
        for (int i = 0; i < DW; i++) folded = shift1(folded, poly);
      end
      assign busy = 1'b0;
      always_ff @(posedge clk) begin
        if (rst)            rem <= '0;
        else if (byte_fire) rem <= folded;
        else if (clr)       rem <= base;
      end
    end
  endgenerate
endmodule

// File: rtl/crc16_rdmux.sv
module crc16_rdmux
  import crc16_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] rem,
  input  logic [CW-1:0] poly,
  input  ctrl_t         ctrl,
  input  logic          busy,
  output logic [DW-1:0] rdata
);
  logic [CW-1:0] rev, shown;
  always_comb begin
    for (int i = 0; i < CW; i++) rev[i] = rem[CW-1-i];
    shown = ctrl.flip ? rev : rem;
    if (ctrl.inv) shown = ~shown;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        A_CTRL:    rdata <= DW'({busy, 2'b00, ctrl.flip, ctrl.dma, ctrl.inv, 1'b0, ctrl.seed});
        A_POLY_LO: rdata <= poly[DW-1:0];
        A_POLY_HI: rdata <= poly[CW-1:DW];
        A_RES_LO:  rdata <= shown[DW-1:0];
        A_RES_HI:  rdata <= shown[CW-1:DW];
        default:   rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/crc16_prog.sv
module crc16_prog
  import crc16_pkg::*;
#(
  parameter int DW = 8,
  parameter bit SERIAL = 1'b1,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_ready,
  input  logic          dma_valid,
  input  logic [DW-1:0] dma_data,
  output logic          dma_ready,
  output logic          busy
);
  ctrl_t         ctrl_q;
  logic [CW-1:0] poly_q, rem_q;
  logic          clr_fire, clr_seed, sw_byte_fire, byte_fire, dma_mode;
  logic [DW-1:0] byte_in;

  assign dma_mode  = ctrl_q.dma;
  assign reg_ready = !busy;
  assign dma_ready = dma_mode && !busy;
  assign byte_fire = dma_mode ? (dma_valid && dma_ready) : sw_byte_fire;
  assign byte_in   = dma_mode ? dma_data : reg_wdata;

  crc16_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .busy(busy), .ctrl(ctrl_q), .poly(poly_q), .clr_fire(clr_fire),
    .clr_seed(clr_seed), .sw_byte_fire(sw_byte_fire)
  );

  crc16_core #(.DW(DW), .SERIAL(SERIAL)) u_core (
    .clk(clk), .rst(rst), .poly(poly_q), .clr(clr_fire), .seed(clr_seed),
    .byte_fire(byte_fire), .byte_in(byte_in), .rem(rem_q), .busy(busy)
  );

  crc16_rdmux #(.DW(DW)) u_rd (
    .clk(clk), .rst(rst), .addr(reg_addr), .rem(rem_q), .poly(poly_q),
    .ctrl(ctrl_q), .busy(busy), .rdata(reg_rdata)
  );
endmodule

// File: rtl/crc16_prog_chk.sv
module crc16_prog_chk #(
  parameter int CW = 16,
  parameter bit SERIAL = 1'b1
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          reg_ready,
  input logic          dma_ready,
  input logic          dma_mode,
  input logic [CW-1:0] rem,
  input logic          clr_fire,
  input logic          clr_seed,
  input logic          byte_fire
);
  a_r1_reset_state: assert property (@(posedge clk) rst |=> (rem == '0) && !busy);

  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    busy |-> !reg_ready && !dma_ready);

  a_r10_dma_gated: assert property (@(posedge clk) disable iff (rst)
    !dma_mode |-> !dma_ready);

  a_r3_clear_seed: assert property (@(posedge clk) disable iff (rst)
    clr_fire && !byte_fire |=> rem == ($past(clr_seed) ? {CW{1'b1}} : {CW{1'b0}}));

  a_r5_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !busy && !byte_fire && !clr_fire |=> $stable(rem));

  generate
    if (SERIAL) begin : g_ser
      a_r8_busy_after_byte: assert property (@(posedge clk) disable iff (rst)
        byte_fire |=> busy);
    end
  endgenerate
endmodule

bind crc16_prog crc16_prog_chk #(.CW(CW), .SERIAL(SERIAL)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .reg_ready(reg_ready), .dma_ready(dma_ready),
  .dma_mode(dma_mode), .rem(rem_q), .clr_fire(clr_fire), .clr_seed(clr_seed),
  .byte_fire(byte_fire)
);

// File: tb/test_crc16_prog.sv
module test_crc16_prog;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       reg_ready;
  logic       dma_valid = 1'b0;
  logic [7:0] dma_data = '0;
  logic       dma_ready;
  logic       busy;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  crc16_prog i_crc16_prog (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ready(reg_ready), .dma_valid(dma_valid),
    .dma_data(dma_data), .dma_ready(dma_ready), .busy(busy)
  );

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  logic [15:0] m_rem = '0;
  logic [15:0] m_poly = '0;

  function automatic logic [15:0] fold(input logic [15:0] r, input logic [15:0] p, input logic [7:0] b);
    logic [15:0] x;
    x = r ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) x = x[15] ? ((x << 1) ^ p) : (x << 1);
    return x;
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] o;
    for (int i = 0; i < 16; i++) o[i] = v[15-i];
    return o;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per read, sampled after the registered read updates
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, {8'h00, reg_rdata}, {8'h00, it.exp});
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    sb.push_back('{exp: exp, tag: tag});
    @(posedge clk);
    #4;
  endtask

  task automatic rd_res(input logic [15:0] exp, input string tag);
    rd(3'd4, exp[7:0], tag);
    rd(3'd5, exp[15:8], tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    wait_idle();
    wr(3'd3, b);
    m_rem = fold(m_rem, m_poly, b);
  endtask

  task automatic dma_send(input logic [7:0] b);
    @(negedge clk);
    while (!dma_ready) @(negedge clk);
    dma_valid = 1'b1; dma_data = b;
    @(negedge clk);
    dma_valid = 1'b0;
    m_rem = fold(m_rem, m_poly, b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R10 dma_ready outside DMA mode", {15'd0, dma_ready}, 16'd0);
    rd(3'd0, 8'h00, "R1 ctrl");
    rd(3'd1, 8'h00, "R1 poly lo");
    rd_res(16'h0000, "R1 result");

    // R2 polynomial
    wr(3'd1, 8'h21); wr(3'd2, 8'h10); m_poly = 16'h1021;
    rd(3'd1, 8'h21, "R2 poly lo");
    rd(3'd2, 8'h10, "R2 poly hi");

    // R3 clear with seed, clear bit reads 0
    wr(3'd0, 8'h03); m_rem = 16'hFFFF;
    rd(3'd0, 8'h01, "R3 clear bit reads 0");
    rd_res(16'hFFFF, "R3/R7 seeded clear");
    wr(3'd0, 8'h00);

    // R4 and R8: first byte with busy timing
    wait_idle();
    wr(3'd3, 8'h31); m_rem = fold(m_rem, m_poly, 8'h31);
    check("R8 busy after byte", {15'd0, busy}, 16'd1);
    check("R8 reg_ready low", {15'd0, reg_ready}, 16'd0);
    rd(3'd0, 8'h80, "R8 ctrl busy bit");
    // R9: write while busy is dropped
    wr(3'd3, 8'hAA);
    wait_idle();
    rd_res(m_rem, "R9 ignored write while busy");
    for (int i = 2; i <= 9; i++) send(8'(8'h30 + i));
    wait_idle();
    check("R4 known check value", m_rem, 16'h29B1);
    rd_res(m_rem, "R4 fold of 9 bytes");

    // R8 exact busy length
    wait_idle();
    wr(3'd3, 8'h5A); m_rem = fold(m_rem, m_poly, 8'h5A);
    n = 0;
    while (busy) begin @(negedge clk); n++; end
    check("R8 busy length", 16'(n), 16'd8);

    // R5 / R6 output options
    wr(3'd0, 8'h04); rd_res(~m_rem, "R5 invert");
    wr(3'd0, 8'h10); rd_res(rev16(m_rem), "R6 flip");
    wr(3'd0, 8'h14); rd_res(~rev16(m_rem), "R6 invert and flip");
    wr(3'd0, 8'h00); rd_res(m_rem, "R6 raw restored");

    // R3 clear without seed, different polynomial
    wr(3'd0, 8'h02); m_rem = 16'h0000;
    rd_res(16'h0000, "R3 zero clear");
    wr(3'd1, 8'h05); wr(3'd2, 8'h80); m_poly = 16'h8005;
    send(8'hFF); send(8'h00); send(8'h80); send(8'h01);
    wait_idle();
    rd_res(m_rem, "R4 poly 8005 pattern");

    // R10 DMA mode
    wr(3'd0, 8'h08);
    rd(3'd0, 8'h08, "R10 dma bit");
    wr(3'd3, 8'h55);
    @(negedge clk);
    check("R10 sw write ignored busy", {15'd0, busy}, 16'd0);
    rd_res(m_rem, "R10 sw write ignored");
    dma_send(8'h12); dma_send(8'h34); dma_send(8'hC7);
    wait_idle();
    rd_res(m_rem, "R10 dma stream");

    // R11 clear and DMA byte in the same cycle
    @(negedge clk);
    while (!dma_ready) @(negedge clk);
    dma_valid = 1'b1; dma_data = 8'h9E;
    reg_addr = 3'd0; reg_wdata = 8'h0B; reg_wr = 1'b1;
    @(negedge clk);
    dma_valid = 1'b0; reg_wr = 1'b0;
    m_rem = fold(16'hFFFF, m_poly, 8'h9E);
    wait_idle();
    rd_res(m_rem, "R11 seed then byte");
    wr(3'd0, 8'h00);
    @(negedge clk);
    check("R10 dma_ready off after mode cleared", {15'd0, dma_ready}, 16'd0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule